// File: doc/BRIEF.md
# System Management Memory Window Controller

This block combines one byte-wide control register with an address decoder for the protected memory areas that system-management code uses. Software programs the register through a small configuration port. For every CPU access the decoder then decides whether DRAM takes the cycle or the cycle is passed to the PCI bus.

Two protected windows exist. The first is a fixed high alias window. The second is a top-of-memory segment whose size is selectable and whose alias sits 256 MB above the end of DRAM. When the segment is active, the physical DRAM it is carved from is no longer claimed. Touching either window outside system-management mode, while the open override is low, sends the cycle to PCI and latches a sticky error bit. Software clears that bit by writing a one to it. The block also reports L1 and L2 writeback cacheability for the protected area. L2 is granted only together with L1.

Top module: `smram_window_ctl`

## Requirements
- R1: After reset the register reads 8'h00, and both cacheability outputs are 0.
- R2: A configuration write at offset 8'h71 stores bits 7, 4, 3, 2:1 and 0. Bit 5 always reads 0. A read at any other offset returns 0. A write at any other offset leaves the register unchanged.
- R3: Bit 6 is the error flag. It stays set until a write at offset 8'h71 with data bit 6 = 1 clears it. A write with data bit 6 = 0 leaves it unchanged.
- R4: If a violation and a clearing write occur in the same cycle, the error flag reads 1 afterwards.
- R5: With bit 7 = 1 and the global enable = 1, addresses from 32'h100A0000 up to but not including 32'h100F0000 form the high window. Without both enables the high window does not exist.
- R6: Bits 2:1 select the segment size: 00 = 128 KB, 01 = 256 KB, 10 = 512 KB, 11 = 1 MB. The segment alias spans [32'h10000000 + top_of_mem - size, 32'h10000000 + top_of_mem).
- R7: The segment is active only when bit 0 = 1 and the global enable = 1. While it is active, accesses to [top_of_mem - size, top_of_mem) go to PCI.
- R8: An access to an active window is claimed by DRAM when smm_active or smram_open is 1. Otherwise it goes to PCI and sets bit 6 at the next clock edge.
- R9: Any other access is claimed by DRAM when its address is below top_of_mem, and goes to PCI otherwise.
- R10: ext_l1_wb equals bit 4. ext_l2_wb equals bit 3 AND bit 4.
- R11: With acc_valid = 1, exactly one of dram_claim and pci_fwd is 1. With acc_valid = 0, both are 0 and no error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_addr | input | 8 | Configuration offset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| acc_valid | input | 1 | CPU access present this cycle |
| acc_addr | input | 32 | CPU physical address |
| smm_active | input | 1 | CPU is in system-management mode |
| smram_global_en | input | 1 | Global enable for the protected memory |
| smram_open | input | 1 | Override that opens the windows to normal code |
| top_of_mem | input | 32 | End of installed DRAM (byte address) |
| dram_claim | output | 1 | DRAM takes the access |
| pci_fwd | output | 1 | Access is passed to PCI |
| ext_l1_wb | output | 1 | Protected area may be L1 writeback cached |
| ext_l2_wb | output | 1 | Protected area may be L2 writeback cached |

## Verification
The assertions assume that top_of_mem is at least 1 MB and stays below the point where 32'h10000000 + top_of_mem would overflow the address width. They also assume the address inputs are stable between clock edges. The stimulus uses a fixed 64 MB top of memory and drives every input on the falling edge. Violations are generated only through acc_valid, one cycle at a time, so the sticky-error properties see each set and clear on a known edge.

// File: rtl/smram_window_ctl.sv
module smram_window_ctl #(
  parameter int ADDR_W = 32,
  parameter logic [7:0] CFG_OFFSET = 8'h71,
  parameter logic [ADDR_W-1:0] HI_BASE = 'h100A_0000,
  parameter logic [ADDR_W-1:0] HI_LIMIT = 'h100F_0000,
  parameter logic [ADDR_W-1:0] ALIAS_BASE = 'h1000_0000,
  parameter logic [ADDR_W-1:0] SEG_MIN = 'h0002_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        cfg_addr,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              smm_active,
  input  logic              smram_global_en,
  input  logic              smram_open,
  input  logic [ADDR_W-1:0] top_of_mem,
  output logic              dram_claim,
  output logic              pci_fwd,
  output logic              ext_l1_wb,
  output logic              ext_l2_wb
);

  logic       hi_en, err, l1_en, l2_en, seg_en;
  logic [1:0] seg_sel;
  logic       unused_wbit;

  logic              sel_hit, wr_hit, clr_req;
  logic              hi_on, seg_on, allowed;
  logic [ADDR_W-1:0] seg_size, alias_top, alias_bot, carve_bot;
  logic              in_hi, in_alias, in_carve, in_prot, viol, claim_raw;

  assign unused_wbit = cfg_wdata[5];
  assign sel_hit = (cfg_addr == CFG_OFFSET);
  assign wr_hit  = cfg_wr && sel_hit;
  assign clr_req = wr_hit && cfg_wdata[6];

  assign hi_on   = hi_en && smram_global_en;
  assign seg_on  = seg_en && smram_global_en;
  assign allowed = smm_active || smram_open;

  assign seg_size  = SEG_MIN << seg_sel;
  assign alias_top = ALIAS_BASE + top_of_mem;
  assign alias_bot = alias_top - seg_size;
  assign carve_bot = top_of_mem - seg_size;

  assign in_hi    = hi_on && (acc_addr >= HI_BASE) && (acc_addr < HI_LIMIT);
  assign in_alias = seg_on && (acc_addr >= alias_bot) && (acc_addr < alias_top);
  assign in_carve = seg_on && (acc_addr >= carve_bot) && (acc_addr < top_of_mem);
  assign in_prot  = in_hi || in_alias;
  assign viol     = acc_valid && in_prot && !allowed;

  always_comb begin
    if (in_prot)       claim_raw = allowed;
    else if (in_carve) claim_raw = 1'b0;
    else               claim_raw = (acc_addr < top_of_mem);
  end

  assign dram_claim = acc_valid && claim_raw;
  assign pci_fwd    = acc_valid && !claim_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_en   <= 1'b0;
      l1_en   <= 1'b0;
      l2_en   <= 1'b0;
      seg_sel <= 2'b00;
      seg_en  <= 1'b0;
      err     <= 1'b0;
    end else begin
      if (wr_hit) begin
        hi_en   <= cfg_wdata[7];
        l1_en   <= cfg_wdata[4];
        l2_en   <= cfg_wdata[3];
        seg_sel <= cfg_wdata[2:1];
        seg_en  <= cfg_wdata[0];
      end
      err <= viol || (err && !clr_req);
    end
  end

  assign cfg_rdata = sel_hit ? {hi_en, err, 1'b0, l1_en, l2_en, seg_sel, seg_en} : 8'h00;
  assign ext_l1_wb = l1_en;
  assign ext_l2_wb = l1_en && l2_en;

  AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !viol) |=> !cfg_rdata[6] || !sel_hit); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !clr_req) |=> err); // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> err); // R4
  AST_VIOL_TO_PCI: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> (pci_fwd && !dram_claim)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (!dram_claim && !pci_fwd)); // R11

endmodule

// File: tb/sim_smram_window_ctl.sv
module sim_smram_window_ctl;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] TOM = 32'h0400_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_addr = 8'h71;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = 32'h0;
  logic        smm_active = 1'b0;
  logic        smram_global_en = 1'b0;
  logic        smram_open = 1'b0;
  logic [31:0] top_of_mem = TOM;
  logic        dram_claim, pci_fwd, ext_l1_wb, ext_l2_wb;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smram_window_ctl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .smm_active(smm_active),
    .smram_global_en(smram_global_en), .smram_open(smram_open),
    .top_of_mem(top_of_mem), .dram_claim(dram_claim), .pci_fwd(pci_fwd),
    .ext_l1_wb(ext_l1_wb), .ext_l2_wb(ext_l2_wb)
  );

  // ctl[44:37] glob[36] smm[35] open[34] addr[33:2] claim[1] pci[0]
  localparam int NV = 24;
  localparam logic [44:0] VEC [0:NV-1] = '{
    {8'h80, 1'b1, 1'b1, 1'b0, 32'h100A_0000, 1'b1, 1'b0},
    {8'h80, 1'b1, 1'b1, 1'b0, 32'h100E_FFFF, 1'b1, 1'b0},
    {8'h80, 1'b1, 1'b1, 1'b0, 32'h100F_0000, 1'b0, 1'b1},
    {8'h80, 1'b1, 1'b1, 1'b0, 32'h1009_FFFF, 1'b0, 1'b1},
    {8'h80, 1'b0, 1'b1, 1'b0, 32'h100A_0000, 1'b0, 1'b1},
    {8'h80, 1'b1, 1'b0, 1'b1, 32'h100B_0000, 1'b1, 1'b0},
    {8'h80, 1'b1, 1'b0, 1'b0, 32'h100B_0000, 1'b0, 1'b1},
    {8'h00, 1'b1, 1'b1, 1'b0, 32'h100A_0000, 1'b0, 1'b1},
    {8'h01, 1'b1, 1'b1, 1'b0, 32'h13FE_0000, 1'b1, 1'b0},
    {8'h01, 1'b1, 1'b1, 1'b0, 32'h13FD_FFFF, 1'b0, 1'b1},
    {8'h01, 1'b1, 1'b1, 1'b0, 32'h13FF_FFFF, 1'b1, 1'b0},
    {8'h01, 1'b1, 1'b1, 1'b0, 32'h1400_0000, 1'b0, 1'b1},
    {8'h03, 1'b1, 1'b1, 1'b0, 32'h13FC_0000, 1'b1, 1'b0},
    {8'h05, 1'b1, 1'b1, 1'b0, 32'h13F8_0000, 1'b1, 1'b0},
    {8'h07, 1'b1, 1'b1, 1'b0, 32'h13F0_0000, 1'b1, 1'b0},
    {8'h05, 1'b1, 1'b1, 1'b0, 32'h13F7_FFFF, 1'b0, 1'b1},
    {8'h01, 1'b1, 1'b1, 1'b0, 32'h03FE_0000, 1'b0, 1'b1},
    {8'h01, 1'b0, 1'b1, 1'b0, 32'h03FE_0000, 1'b1, 1'b0},
    {8'h01, 1'b0, 1'b1, 1'b0, 32'h13FE_0000, 1'b0, 1'b1},
    {8'h07, 1'b1, 1'b1, 1'b0, 32'h03F0_0000, 1'b0, 1'b1},
    {8'h01, 1'b1, 1'b1, 1'b0, 32'h03FD_FFFF, 1'b1, 1'b0},
    {8'h00, 1'b1, 1'b0, 1'b0, 32'h0000_1000, 1'b1, 1'b0},
    {8'h00, 1'b1, 1'b0, 1'b0, 32'h0400_0000, 1'b0, 1'b1},
    {8'h01, 1'b1, 1'b0, 1'b0, 32'h13FE_0000, 1'b0, 1'b1}
  };

  function automatic string vec_req(input int i);
    if (i <= 5)       return "R5";
    else if (i == 6)  return "R8";
    else if (i == 7)  return "R5";
    else if (i <= 15) return "R6";
    else if (i <= 20) return "R7";
    else if (i <= 22) return "R9";
    else              return "R8";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] off, input logic [7:0] data);
    @(negedge clk);
    cfg_addr = off; cfg_wdata = data; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_addr = 8'h71;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 reset value", {24'h0, cfg_rdata}, 32'h00);
    check("R1 reset cache", {30'h0, ext_l1_wb, ext_l2_wb}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      cfg_write(8'h71, VEC[i][44:37]);
      smram_global_en = VEC[i][36];
      smm_active = VEC[i][35];
      smram_open = VEC[i][34];
      acc_addr = VEC[i][33:2];
      acc_valid = 1'b1;
      #1;
      check(vec_req(i), {30'h0, dram_claim, pci_fwd}, {30'h0, VEC[i][1], VEC[i][0]});
      @(negedge clk);
      acc_valid = 1'b0;
    end

    // R2: storage, reserved bit, other offsets
    cfg_write(8'h71, 8'hC0);
    cfg_write(8'h71, 8'hBF);
    #1 check("R2 write all but error", {24'h0, cfg_rdata}, 32'h9F);
    cfg_write(8'h72, 8'h00);
    #1 check("R2 other offset write ignored", {24'h0, cfg_rdata}, 32'h9F);
    cfg_addr = 8'h70;
    #1 check("R2 other offset reads zero", {24'h0, cfg_rdata}, 32'h00);
    cfg_addr = 8'h71;

    // R10: cacheability
    cfg_write(8'h71, 8'h18);
    #1 check("R10 l1 and l2", {30'h0, ext_l1_wb, ext_l2_wb}, 32'h3);
    cfg_write(8'h71, 8'h08);
    #1 check("R10 l2 without l1", {30'h0, ext_l1_wb, ext_l2_wb}, 32'h0);
    cfg_write(8'h71, 8'h10);
    #1 check("R10 l1 only", {30'h0, ext_l1_wb, ext_l2_wb}, 32'h2);

    // R8: violation sets error
    cfg_write(8'h71, 8'h80);
    smram_global_en = 1'b1; smm_active = 1'b0; smram_open = 1'b0;
    acc_addr = 32'h100A_0000; acc_valid = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0;
    #1 check("R8 error set", {31'h0, cfg_rdata[6]}, 32'h1);

    // R3: write 0 keeps, write 1 clears
    cfg_write(8'h71, 8'h80);
    #1 check("R3 write zero keeps error", {31'h0, cfg_rdata[6]}, 32'h1);
    cfg_write(8'h71, 8'hC0);
    #1 check("R3 write one clears error", {31'h0, cfg_rdata[6]}, 32'h0);

    // R4: set and clear together
    @(negedge clk);
    cfg_addr = 8'h71; cfg_wdata = 8'hC0; cfg_wr = 1'b1; acc_valid = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; acc_valid = 1'b0;
    #1 check("R4 set wins over clear", {31'h0, cfg_rdata[6]}, 32'h1);
    cfg_write(8'h71, 8'hC0);

    // R11: no access, no claim, no error
    acc_valid = 1'b0;
    @(negedge clk);
    #1 check("R11 idle outputs", {30'h0, dram_claim, pci_fwd}, 32'h0);
    check("R11 idle no error", {31'h0, cfg_rdata[6]}, 32'h0);

    // R8: global enable off removes the window, no error
    smram_global_en = 1'b0; acc_valid = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0;
    #1 check("R8 no error when globally off", {31'h0, cfg_rdata[6]}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule